// File: doc/BRIEF.md
# Serial Channel Transmit Buffer with Underrun Detection

This block is the transmit side of a single channel in a serial controller. The CPU puts characters into a one-slot holding buffer. Control writes set the channel up and issue commands. A two-stage pipe, holding slot then shift stage, hands characters to the line once per character period. A character-period strobe from outside sets the pace. Each character that leaves the shift stage appears on a parallel output with a one-cycle done pulse. The block does not produce parity, stop bits or sync patterns.

The block raises an interrupt when the holding slot empties into the shift stage. It also flags an underrun when a character period finds nothing to send, and the underrun flag stays set until a command clears it. The transmitter runs only while its enable bit is set. A falling clear-to-send input can set that bit when auto-enable is on. In synchronous modes, the first character after idle is taken on a half-bit strobe, so it starts half a bit early. A channel-reset command returns the whole channel to its idle state.

Control fields used by this block:

| Register | Bits | Meaning |
|---|---|---|
| 0 | 0x18 | Channel reset |
| 0 | 7:6 = 11 | Clear underrun |
| 1 | bit 0 | Underrun interrupt enable |
| 1 | bit 1 | Holding-empty interrupt enable |
| 3 | bit 5 | Auto-enable |
| 4 | bits 3:2 | Mode (nonzero means synchronous) |
| 5 | bit 3 | Transmitter enable |

Top module: `txbuf_top`

## Requirements
- R1: After the synchronous reset input, tx_done, tx_en, underrun and irq are all 0, and the holding slot and shift stage are empty.
- R2: The holding slot keeps one character. A data write while the slot is full replaces the older character, and only the newest character is ever sent.
- R3: A character event is a char_tick while the transmitter is enabled. On each event, a full shift stage sends its character: in the next cycle tx_data holds that character and tx_done is 1 for exactly that one cycle. The shift stage is then marked empty, and a full holding slot then moves into it. A character therefore goes out on the second event after it is written into an idle channel.
- R4: An event that finds both the shift stage and the holding slot empty sets underrun. Underrun stays set until a write of a value with bits 7:6 = 11 to register 0, or until a channel reset.
- R5: Events happen only while register 5 bit 3 (transmitter enable) is 1, and tx_en shows this bit. While the bit is 0, char_tick and half_tick have no effect: nothing is sent, nothing moves between stages and underrun is not set.
- R6: A falling edge of cts_n forces register 5 bit 3 to 1 in the next cycle, but only while register 3 bit 5 (auto-enable) is 1. With auto-enable 0, a falling edge leaves the bit as it is.
- R7: In synchronous modes (register 4 bits 3:2 nonzero), the block arms an early start in either of two cases. The first is a data write while the transmitter is enabled and both stages are empty. The second is an enabling action (a write of register 5 with bit 3 = 1, or the cts_n auto-enable) while the shift stage is empty and the holding slot is full. While armed, a half_tick acts as an event, and any event disarms. In the asynchronous mode (bits 3:2 = 00), half_tick has no effect.
- R8: Writing 0x18 to register 0 is a channel reset. It cancels a pending early start, empties the holding slot and the shift stage, clears underrun and the holding-empty interrupt, and zeroes every control field, so tx_en reads 0 afterwards.
- R9: An event that moves a character from the holding slot into the shift stage sets a holding-empty interrupt, if register 1 bit 1 is 1. A data write clears that interrupt. irq is 1 while the interrupt is set, or while underrun is set and register 1 bit 0 is 1.
- R10: When a data write and an event fall in the same cycle, the event acts on the older contents and the new character stays in the holding slot. The holding-empty interrupt ends that cycle cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_we | input | 1 | CPU write strobe for transmit data |
| data_in | input | 8 | Character to transmit |
| ctrl_we | input | 1 | CPU write strobe for a control register |
| ctrl_sel | input | 3 | Control register index |
| ctrl_data | input | 8 | Control register write value |
| cts_n | input | 1 | Clear-to-send, active low |
| char_tick | input | 1 | One-cycle strobe, once per character period |
| half_tick | input | 1 | One-cycle strobe at the half-bit point |
| tx_data | output | 8 | Last character sent |
| tx_done | output | 1 | One-cycle pulse when a character leaves the shift stage |
| tx_en | output | 1 | Transmitter enable bit |
| underrun | output | 1 | Sticky underrun flag |
| irq | output | 1 | Interrupt request |

## Verification
Every result of this block is registered. A strobe or write applied before a clock edge shows at the ports one cycle after that edge. That cycle-later result covers the done pulse with its character, the underrun flag, the enable bit and the interrupt. A character written into an idle channel reaches tx_data only after a second character event, because it first has to pass through the shift stage. The bench applies inputs on the falling edge, so each rising edge takes in one stimulus. A behavioural model advances on that same rising edge, and the following falling edge compares every output with the model. Spot checks placed right after each stimulus confirm the expected one-cycle latency and the two-event pipe depth with literal values.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;

    localparam int CHAR_W   = 8;
    localparam int NREG     = 8;
    localparam int SEL_W    = $clog2(NREG);

    localparam logic [SEL_W-1:0] SEL_CMD  = SEL_W'(0);
    localparam logic [SEL_W-1:0] SEL_IEN  = SEL_W'(1);
    localparam logic [SEL_W-1:0] SEL_AUTO = SEL_W'(3);
    localparam logic [SEL_W-1:0] SEL_MODE = SEL_W'(4);
    localparam logic [SEL_W-1:0] SEL_TXC  = SEL_W'(5);

    localparam int BIT_IEN_URUN = 0;
    localparam int BIT_IEN_TXE  = 1;
    localparam int BIT_AUTO     = 5;
    localparam int BIT_MODE_LO  = 2;
    localparam int BIT_TXEN     = 3;

    localparam logic [CHAR_W-1:0] CMD_CHAN_RESET = CHAR_W'(8'h18);

    typedef struct packed {
        logic       ien_urun;
        logic       ien_txe;
        logic       auto_en;
        logic [1:0] mode;
        logic       txen;
    } ctrl_t;

    typedef struct packed {
        logic              full;
        logic [CHAR_W-1:0] ch;
    } slot_t;

    localparam ctrl_t CTRL_ZERO = '0;
    localparam slot_t SLOT_EMPTY = '0;

    function automatic logic is_sync(input logic [1:0] mode);
        return |mode;
    endfunction

    function automatic logic is_urun_clear(input logic [CHAR_W-1:0] d);
        return d[CHAR_W-1 -: 2] == 2'b11;
    endfunction

endpackage

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl
    import txbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [SEL_W-1:0]  ctrl_sel,
    input  logic [CHAR_W-1:0] ctrl_data,
    input  logic              cts_n,
    output ctrl_t             cfg,
    output logic              chan_reset,
    output logic              urun_clr,
    output logic              cts_force,
    output logic              en_req
);

    ctrl_t cfg_q, cfg_d;
    logic  cts_prev;

    assign chan_reset = ctrl_we && (ctrl_sel == SEL_CMD) && (ctrl_data == CMD_CHAN_RESET);
    assign urun_clr   = ctrl_we && (ctrl_sel == SEL_CMD) && is_urun_clear(ctrl_data);
    assign cts_force  = cts_prev && !cts_n && cfg_q.auto_en;
    assign en_req     = (ctrl_we && (ctrl_sel == SEL_TXC) && ctrl_data[BIT_TXEN]) || cts_force;
    assign cfg        = cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (ctrl_we) begin
            case (ctrl_sel)
                SEL_IEN: begin
                    cfg_d.ien_urun = ctrl_data[BIT_IEN_URUN];
                    cfg_d.ien_txe  = ctrl_data[BIT_IEN_TXE];
                end
                SEL_AUTO: cfg_d.auto_en = ctrl_data[BIT_AUTO];
                SEL_MODE: cfg_d.mode    = ctrl_data[BIT_MODE_LO +: 2];
                SEL_TXC:  cfg_d.txen    = ctrl_data[BIT_TXEN];
                default:  ;
            endcase
        end
        if (cts_force) begin
            cfg_d.txen = 1'b1;
        end
        if (chan_reset) begin
            cfg_d = CTRL_ZERO;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= CTRL_ZERO;
            cts_prev <= 1'b1;
        end else begin
            cfg_q    <= cfg_d;
            cts_prev <= cts_n;
        end
    end

endmodule

// File: rtl/txbuf_sched.sv
module txbuf_sched
    import txbuf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic txen,
    input  logic sync_mode,
    input  logic char_tick,
    input  logic half_tick,
    input  logic data_we,
    input  logic en_req,
    input  logic chan_reset,
    input  logic shift_full,
    input  logic hold_full,
    output logic evt,
    output logic armed
);

    logic arm_on_write, arm_on_enable, arm_set;

    assign evt           = txen && (char_tick || (armed && half_tick));
    assign arm_on_write  = data_we && txen && !shift_full && !hold_full;
    assign arm_on_enable = en_req && !shift_full && hold_full;
    assign arm_set       = sync_mode && (arm_on_write || arm_on_enable);

    always_ff @(posedge clk) begin
        if (rst || chan_reset) begin
            armed <= 1'b0;
        end else if (arm_set) begin
            armed <= 1'b1;
        end else if (evt || !txen) begin
            armed <= 1'b0;
        end
    end

endmodule

// File: rtl/txbuf_path.sv
module txbuf_path
    import txbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  logic              data_we,
    input  logic [CHAR_W-1:0] data_in,
    input  logic              chan_reset,
    input  logic              urun_clr,
    input  logic              ien_txe,
    output slot_t             hold,
    output slot_t             shift,
    output logic [CHAR_W-1:0] tx_data,
    output logic              tx_done,
    output logic              underrun,
    output logic              txe_pend
);

    logic moves, starved;

    assign moves   = evt && hold.full;
    assign starved = evt && !hold.full && !shift.full;

    always_ff @(posedge clk) begin
        if (rst || chan_reset) begin
            hold  <= SLOT_EMPTY;
            shift <= SLOT_EMPTY;
        end else begin
            if (evt) begin
                shift <= hold;
            end
            if (data_we) begin
                hold <= '{full: 1'b1, ch: data_in};
            end else if (moves) begin
                hold.full <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_data <= '0;
            tx_done <= 1'b0;
        end else begin
            tx_done <= evt && shift.full && !chan_reset;
            if (evt && shift.full) begin
                tx_data <= shift.ch;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || chan_reset) begin
            underrun <= 1'b0;
            txe_pend <= 1'b0;
        end else begin
            if (urun_clr) begin
                underrun <= 1'b0;
            end else if (starved) begin
                underrun <= 1'b1;
            end
            if (data_we) begin
                txe_pend <= 1'b0;
            end else if (moves && ien_txe) begin
                txe_pend <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/txbuf_top.sv
module txbuf_top
    import txbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              data_we,
    input  logic [CHAR_W-1:0] data_in,
    input  logic              ctrl_we,
    input  logic [SEL_W-1:0]  ctrl_sel,
    input  logic [CHAR_W-1:0] ctrl_data,
    input  logic              cts_n,
    input  logic              char_tick,
    input  logic              half_tick,
    output logic [CHAR_W-1:0] tx_data,
    output logic              tx_done,
    output logic              tx_en,
    output logic              underrun,
    output logic              irq
);

    ctrl_t cfg;
    slot_t hold, shift;
    logic  chan_reset, urun_clr, cts_force, en_req;
    logic  evt, armed, txe_pend;

    txbuf_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (ctrl_we),
        .ctrl_sel   (ctrl_sel),
        .ctrl_data  (ctrl_data),
        .cts_n      (cts_n),
        .cfg        (cfg),
        .chan_reset (chan_reset),
        .urun_clr   (urun_clr),
        .cts_force  (cts_force),
        .en_req     (en_req)
    );

    txbuf_sched u_sched (
        .clk        (clk),
        .rst        (rst),
        .txen       (cfg.txen),
        .sync_mode  (is_sync(cfg.mode)),
        .char_tick  (char_tick),
        .half_tick  (half_tick),
        .data_we    (data_we),
        .en_req     (en_req),
        .chan_reset (chan_reset),
        .shift_full (shift.full),
        .hold_full  (hold.full),
        .evt        (evt),
        .armed      (armed)
    );

    txbuf_path u_path (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .data_we    (data_we),
        .data_in    (data_in),
        .chan_reset (chan_reset),
        .urun_clr   (urun_clr),
        .ien_txe    (cfg.ien_txe),
        .hold       (hold),
        .shift      (shift),
        .tx_data    (tx_data),
        .tx_done    (tx_done),
        .underrun   (underrun),
        .txe_pend   (txe_pend)
    );

    assign tx_en = cfg.txen;
    assign irq   = txe_pend || (underrun && cfg.ien_urun);

endmodule

// File: rtl/txbuf_chk.sv
module txbuf_chk
    import txbuf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              data_we,
    input logic [CHAR_W-1:0] data_in,
    input logic              cts_n,
    input logic              tx_done,
    input logic              tx_en,
    input logic              underrun,
    input logic              evt,
    input logic              armed,
    input logic              chan_reset,
    input logic              urun_clr,
    input logic              auto_en,
    input logic              txe_pend,
    input logic              hold_full,
    input logic [CHAR_W-1:0] hold_ch,
    input logic              shift_full
);

    p_done_from_shift_r3: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> $past(evt && shift_full));

    p_replace_r2: assert property (@(posedge clk) disable iff (rst)
        (data_we && !chan_reset) |=> (hold_full && hold_ch == $past(data_in)));

    p_underrun_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (underrun && !urun_clr && !chan_reset) |=> underrun);

    p_no_evt_disabled_r5: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> !evt);

    p_cts_auto_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(cts_n) && auto_en && !chan_reset) |=> tx_en);

    p_arm_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
        (armed && !tx_en) |=> !armed);

    p_chan_reset_r8: assert property (@(posedge clk) disable iff (rst)
        chan_reset |=> (!hold_full && !shift_full && !underrun && !tx_en && !armed && !txe_pend));

    p_txe_clear_r9: assert property (@(posedge clk) disable iff (rst)
        data_we |=> !txe_pend);

endmodule

bind txbuf_top txbuf_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .data_we    (data_we),
    .data_in    (data_in),
    .cts_n      (cts_n),
    .tx_done    (tx_done),
    .tx_en      (tx_en),
    .underrun   (underrun),
    .evt        (evt),
    .armed      (armed),
    .chan_reset (chan_reset),
    .urun_clr   (urun_clr),
    .auto_en    (cfg.auto_en),
    .txe_pend   (txe_pend),
    .hold_full  (hold.full),
    .hold_ch    (hold.ch),
    .shift_full (shift.full)
);

// File: tb/sim_txbuf_top.sv
module sim_txbuf_top;

    localparam int CLK_NS = 10;
    localparam int WATCHDOG_CYC = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       data_we = 1'b0;
    logic [7:0] data_in = '0;
    logic       ctrl_we = 1'b0;
    logic [2:0] ctrl_sel = '0;
    logic [7:0] ctrl_data = '0;
    logic       cts_n = 1'b1;
    logic       char_tick = 1'b0;
    logic       half_tick = 1'b0;
    logic [7:0] tx_data;
    logic       tx_done, tx_en, underrun, irq;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;
    bit cmp_on = 0;
    string cur_req = "R1";

    txbuf_top u0 (
        .clk(clk), .rst(rst), .data_we(data_we), .data_in(data_in),
        .ctrl_we(ctrl_we), .ctrl_sel(ctrl_sel), .ctrl_data(ctrl_data),
        .cts_n(cts_n), .char_tick(char_tick), .half_tick(half_tick),
        .tx_data(tx_data), .tx_done(tx_done), .tx_en(tx_en),
        .underrun(underrun), .irq(irq)
    );

    always #(CLK_NS/2) clk = ~clk;

    // behavioural reference model
    int  m_hold, m_sh, m_out;
    bit  m_hv, m_shv, m_done, m_urun, m_txe, m_armed, m_prev_cts;
    bit  m_txen, m_auto, m_ietx, m_ieur;
    int  m_mode;

    always @(posedge clk) begin
        bit o_en, o_sync, o_shv, o_hv, ev, cfall, creset, arm, enreq;
        if (rst) begin
            m_hv = 0; m_shv = 0; m_done = 0; m_urun = 0; m_txe = 0; m_armed = 0;
            m_txen = 0; m_auto = 0; m_ietx = 0; m_ieur = 0; m_mode = 0;
            m_prev_cts = 1; m_out = 0; m_hold = 0; m_sh = 0;
        end else begin
            o_en = m_txen; o_sync = (m_mode != 0); o_shv = m_shv; o_hv = m_hv;
            ev = o_en && (char_tick || (m_armed && half_tick));
            cfall = m_prev_cts && !cts_n && m_auto;
            creset = ctrl_we && ctrl_sel == 0 && ctrl_data == 8'h18;
            m_done = 0;
            if (ev) begin
                if (o_shv) begin m_done = 1; m_out = m_sh; end
                m_shv = 0;
                if (o_hv) begin
                    m_sh = m_hold; m_shv = 1; m_hv = 0;
                    if (m_ietx) m_txe = 1;
                end else if (!o_shv) m_urun = 1;
            end
            arm = 0;
            if (data_we) begin
                if (o_sync && o_en && !o_shv && !o_hv) arm = 1;
                m_hold = data_in; m_hv = 1; m_txe = 0;
            end
            enreq = 0;
            if (ctrl_we) begin
                case (ctrl_sel)
                    3'd0: if (ctrl_data[7:6] == 2'b11) m_urun = 0;
                    3'd1: begin m_ieur = ctrl_data[0]; m_ietx = ctrl_data[1]; end
                    3'd3: m_auto = ctrl_data[5];
                    3'd4: m_mode = ctrl_data[3:2];
                    3'd5: begin m_txen = ctrl_data[3]; if (ctrl_data[3]) enreq = 1; end
                    default: ;
                endcase
            end
            if (cfall) begin m_txen = 1; enreq = 1; end
            if (enreq && o_sync && !o_shv && o_hv) arm = 1;
            if (ev || !o_en) m_armed = 0;
            if (arm) m_armed = 1;
            m_prev_cts = cts_n;
            if (creset) begin
                m_hv = 0; m_shv = 0; m_done = 0; m_urun = 0; m_txe = 0; m_armed = 0;
                m_txen = 0; m_auto = 0; m_ietx = 0; m_ieur = 0; m_mode = 0;
            end
        end
    end

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            chk({cur_req, " tx_done"}, tx_done == m_done, int'(tx_done), int'(m_done));
            chk({cur_req, " tx_en"}, tx_en == m_txen, int'(tx_en), int'(m_txen));
            chk({cur_req, " underrun"}, underrun == m_urun, int'(underrun), int'(m_urun));
            chk({cur_req, " irq"}, irq == (m_txe || (m_urun && m_ieur)), int'(irq),
                int'(m_txe || (m_urun && m_ieur)));
            if (m_done) chk({cur_req, " tx_data"}, tx_data == m_out[7:0], int'(tx_data), m_out);
        end
    end

    task automatic wr_data(input logic [7:0] d);
        data_we = 1; data_in = d; @(negedge clk); data_we = 0;
    endtask

    task automatic wr_ctrl(input logic [2:0] s, input logic [7:0] d);
        ctrl_we = 1; ctrl_sel = s; ctrl_data = d; @(negedge clk); ctrl_we = 0;
    endtask

    task automatic tick();
        char_tick = 1; @(negedge clk); char_tick = 0;
    endtask

    task automatic half();
        half_tick = 1; @(negedge clk); half_tick = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 0;
        @(negedge clk);
        cmp_on = 1;
        cur_req = "R1";
        chk("R1 tx_done", tx_done == 0, tx_done, 0);
        chk("R1 tx_en", tx_en == 0, tx_en, 0);
        chk("R1 underrun", underrun == 0, underrun, 0);
        chk("R1 irq", irq == 0, irq, 0);

        cur_req = "R5";
        wr_data(8'h41);
        tick();
        chk("R5 no send when disabled", tx_done == 0, tx_done, 0);
        tick();
        chk("R5 no underrun when disabled", underrun == 0, underrun, 0);

        cur_req = "R9";
        wr_ctrl(3'd1, 8'h03);
        wr_ctrl(3'd5, 8'h08);
        chk("R5 tx_en set", tx_en == 1, tx_en, 1);
        cur_req = "R2";
        wr_data(8'h42);
        tick();
        chk("R3 load only", tx_done == 0, tx_done, 0);
        chk("R9 txe irq", irq == 1, irq, 1);
        wr_data(8'h55);
        chk("R9 write clears irq", irq == 0, irq, 0);
        cur_req = "R3";
        tick();
        chk("R3 done", tx_done == 1, tx_done, 1);
        chk("R2 newest char sent", tx_data == 8'h42, tx_data, 8'h42);
        idle(1);
        chk("R3 one-cycle pulse", tx_done == 0, tx_done, 0);
        tick();
        chk("R3 second char", tx_done == 1 && tx_data == 8'h55, tx_data, 8'h55);
        cur_req = "R4";
        chk("R4 no underrun while shift full", underrun == 0, underrun, 0);
        tick();
        chk("R4 underrun set", underrun == 1, underrun, 1);
        idle(3);
        chk("R4 underrun sticky", underrun == 1, underrun, 1);
        wr_ctrl(3'd0, 8'hC0);
        chk("R4 underrun cleared", underrun == 0, underrun, 0);

        cur_req = "R10";
        data_we = 1; data_in = 8'h5A; char_tick = 1;
        @(negedge clk);
        data_we = 0; char_tick = 0;
        chk("R10 event on old state sets underrun", underrun == 1, underrun, 1);
        tick();
        chk("R10 new char kept", tx_done == 0, tx_done, 0);
        tick();
        chk("R10 new char sent", tx_done == 1 && tx_data == 8'h5A, tx_data, 8'h5A);
        wr_ctrl(3'd0, 8'hC0);

        cur_req = "R6";
        wr_ctrl(3'd5, 8'h00);
        chk("R6 disabled", tx_en == 0, tx_en, 0);
        wr_ctrl(3'd3, 8'h20);
        cts_n = 0;
        @(negedge clk);
        chk("R6 auto enable", tx_en == 1, tx_en, 1);
        cts_n = 1;
        idle(2);

        cur_req = "R8";
        tick();
        tick();
        wr_data(8'h66);
        tick();
        wr_data(8'h67);
        chk("R8 underrun before reset", underrun == 1, underrun, 1);
        wr_ctrl(3'd0, 8'h18);
        chk("R8 tx_en zero", tx_en == 0, tx_en, 0);
        chk("R8 underrun zero", underrun == 0, underrun, 0);
        chk("R8 irq zero", irq == 0, irq, 0);
        wr_ctrl(3'd5, 8'h08);
        tick();
        chk("R8 shift emptied", tx_done == 0, tx_done, 0);
        chk("R8 hold emptied", underrun == 1, underrun, 1);
        wr_ctrl(3'd0, 8'hC0);
        wr_ctrl(3'd5, 8'h00);
        cts_n = 0;
        @(negedge clk);
        chk("R6 no auto after reset", tx_en == 0, tx_en, 0);
        cts_n = 1;
        idle(1);

        cur_req = "R7";
        wr_ctrl(3'd5, 8'h08);
        wr_ctrl(3'd4, 8'h04);
        wr_data(8'h77);
        half();
        chk("R7 early load", tx_done == 0, tx_done, 0);
        half();
        chk("R7 half ignored when not armed", tx_done == 0 && underrun == 0, underrun, 0);
        tick();
        chk("R7 early char sent", tx_done == 1 && tx_data == 8'h77, tx_data, 8'h77);
        wr_ctrl(3'd4, 8'h00);
        wr_data(8'h78);
        half();
        tick();
        chk("R7 async loads on tick only", tx_done == 0, tx_done, 0);
        tick();
        chk("R7 async char sent", tx_done == 1 && tx_data == 8'h78, tx_data, 8'h78);
        wr_ctrl(3'd5, 8'h00);
        wr_ctrl(3'd4, 8'h08);
        wr_data(8'h79);
        wr_ctrl(3'd5, 8'h08);
        half();
        tick();
        chk("R7 armed by enable", tx_done == 1 && tx_data == 8'h79, tx_data, 8'h79);
        idle(3);

        finish_run();
    end

endmodule